// File: doc/BRIEF.md
# DRAM Address-Map Configuration Matcher

The block selects an address-map configuration for a DRAM channel. It takes the number of column and row address bits that were detected, a flag that marks a 16-bit data bus, and a requested mapping scheme. It then walks a fixed table of sixteen candidate configurations and reports the first one that fits that scheme's matching rule. Each candidate records a scheme and a (rows, columns) pair.

A one-cycle `start` pulse latches the inputs and begins the search. The search examines one table entry per clock, in ascending index order. When it finds a hit, or when the last entry has been examined, the block raises `done`. At the same time it presents `found` and the selected index. These results stay fixed until the next accepted `start`.

The table holds three schemes, and each has its own rule:

- Column-bank-row-device (code 0) needs both the columns and the rows to match exactly.
- Column-row-bank-device (code 1) needs the columns to be equal and the entry's rows to be no more than the detected rows.
- Column-bank-device-row (code 2) accepts an exact column match. It also accepts a row-exact entry whose columns do not exceed the detected columns.

Top module: `amap_matcher`

## Requirements
- R1: With `busIs16` high, the column count used for matching is `colBits` minus one; with it low, `colBits` is used unchanged.
- R2: Only entries whose scheme equals the requested `scheme` code (0, 1 or 2) can match; code 3 matches no entry. The table is: code 0 at indices 0..10 with (rows,cols) (13,10),(14,10),(15,10),(16,10),(14,11),(15,11),(16,11),(13,9),(14,9),(15,9),(16,9); code 1 at 11..13 with (15,10),(14,11),(13,10); code 2 at 14..15 with (16,10),(16,9).
- R3: Under scheme 0 an entry matches only when its rows and columns both equal the effective values.
- R4: Under scheme 1 an entry matches when its columns equal the effective columns and its rows are less than or equal to `rowBits`.
- R5: Under scheme 2 an entry matches when its columns equal the effective columns, or when its columns are less than or equal to them and its rows equal `rowBits`.
- R6: The lowest-index matching entry is reported, with `found` high. When nothing matches, `found` is low and `matchIdx` is 0. `found` is never high while `done` is low.
- R7: Count the clock edge that samples an accepted `start` as edge 0. A hit at index k raises `done` after edge k+1. A search that finds nothing raises `done` after edge 16.
- R8: `done`, `found` and `matchIdx` hold until a new `start` arrives. A `start` taken while `done` is high drops `done` after the next edge and begins a fresh search on the inputs present at that edge.
- R9: A `start` that arrives while a search is in progress is ignored. Input changes during a search do not affect its result.
- R10: After reset, `done`, `found` and `matchIdx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a search |
| colBits | input | COL_W (4) | Detected column address bits |
| rowBits | input | ROW_W (5) | Detected row address bits |
| busIs16 | input | 1 | High for a 16-bit data bus |
| scheme | input | 2 | Requested mapping scheme code |
| done | output | 1 | Search finished; results valid |
| found | output | 1 | A matching entry was found |
| matchIdx | output | 4 | Index of the selected entry |

## Verification
A `start` pulse can coincide with either of two activities: an ongoing table walk, or the hold of a finished result.

The bench provokes the first case by pulsing `start` with different inputs a few cycles into a long search. It then judges that the original search still ends at its original cycle with its original index.

For the second case, the bench pulses `start` while `done` is high. It then requires that `done` is low one edge later and that the new result arrives with the latency expected from its own inputs.

// File: rtl/amap_pkg.sv
package amap_pkg;

  localparam int MAP_ENTRIES = 16;
  localparam int MAP_IDX_W   = $clog2(MAP_ENTRIES);

  typedef enum logic [1:0] {
    MAP_CBRD = 2'd0,
    MAP_CRBD = 2'd1,
    MAP_CBDR = 2'd2
  } map_scheme_e;

  typedef struct packed {
    map_scheme_e scheme;
    logic [4:0]  rows;
    logic [3:0]  cols;
  } map_entry_t;

  typedef struct packed {
    logic load;
    logic evaluate;
    logic capture;
  } ctrl_strobe_t;

  function automatic map_entry_t amapEntry(input logic [MAP_IDX_W-1:0] i);
    map_entry_t e;
    case (i)
      4'd0:    e = '{MAP_CBRD, 5'd13, 4'd10};
      4'd1:    e = '{MAP_CBRD, 5'd14, 4'd10};
      4'd2:    e = '{MAP_CBRD, 5'd15, 4'd10};
      4'd3:    e = '{MAP_CBRD, 5'd16, 4'd10};
      4'd4:    e = '{MAP_CBRD, 5'd14, 4'd11};
      4'd5:    e = '{MAP_CBRD, 5'd15, 4'd11};
      4'd6:    e = '{MAP_CBRD, 5'd16, 4'd11};
      4'd7:    e = '{MAP_CBRD, 5'd13, 4'd9};
      4'd8:    e = '{MAP_CBRD, 5'd14, 4'd9};
      4'd9:    e = '{MAP_CBRD, 5'd15, 4'd9};
      4'd10:   e = '{MAP_CBRD, 5'd16, 4'd9};
      4'd11:   e = '{MAP_CRBD, 5'd15, 4'd10};
      4'd12:   e = '{MAP_CRBD, 5'd14, 4'd11};
      4'd13:   e = '{MAP_CRBD, 5'd13, 4'd10};
      4'd14:   e = '{MAP_CBDR, 5'd16, 4'd10};
      default: e = '{MAP_CBDR, 5'd16, 4'd9};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/amap_ctrl.sv
module amap_ctrl
  import amap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 hit,
  output ctrl_strobe_t         strobe,
  output logic [MAP_IDX_W-1:0] idx,
  output logic                 done
);

  localparam logic [MAP_IDX_W-1:0] LAST_IDX = MAP_IDX_W'(MAP_ENTRIES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_HOLD} state_e;

  state_e state;
  logic   accept;

  assign accept = start && (state != ST_SCAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else if (accept) begin
      state <= ST_SCAN;
      idx   <= '0;
    end else if (state == ST_SCAN) begin
      if (hit || idx == LAST_IDX) begin
        state <= ST_HOLD;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.load     = accept;
    strobe.evaluate = (state == ST_SCAN);
    strobe.capture  = (state == ST_SCAN) && hit;
  end

  assign done = (state == ST_HOLD);

endmodule

// File: rtl/amap_dpath.sv
module amap_dpath
  import amap_pkg::*;
#(
  parameter int COL_W = 4,
  parameter int ROW_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrl_strobe_t         strobe,
  input  logic [COL_W-1:0]     colBits,
  input  logic [ROW_W-1:0]     rowBits,
  input  logic                 busIs16,
  input  logic [1:0]           scheme,
  input  logic [MAP_IDX_W-1:0] idx,
  output logic                 hit,
  output logic                 found,
  output logic [MAP_IDX_W-1:0] matchIdx
);

  logic [COL_W-1:0] effColsQ;
  logic [ROW_W-1:0] rowsQ;
  logic [1:0]       schemeQ;

  map_entry_t entry;
  logic       colEq, colLe, rowEq, rowLe, sameScheme, ruleOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      effColsQ <= '0;
      rowsQ    <= '0;
      schemeQ  <= '0;
    end else if (strobe.load) begin
      effColsQ <= busIs16 ? (colBits - COL_W'(1)) : colBits;
      rowsQ    <= rowBits;
      schemeQ  <= scheme;
    end
  end

  always_comb begin
    entry      = amapEntry(idx);
    colEq      = (COL_W'(entry.cols) == effColsQ);
    colLe      = (COL_W'(entry.cols) <= effColsQ);
    rowEq      = (ROW_W'(entry.rows) == rowsQ);
    rowLe      = (ROW_W'(entry.rows) <= rowsQ);
    sameScheme = (entry.scheme == schemeQ);
    case (entry.scheme)
      MAP_CBRD: ruleOk = colEq && rowEq;
      MAP_CRBD: ruleOk = colEq && rowLe;
      MAP_CBDR: ruleOk = colEq || (colLe && rowEq);
      default:  ruleOk = 1'b0;
    endcase
    hit = strobe.evaluate && sameScheme && ruleOk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found    <= 1'b0;
      matchIdx <= '0;
    end else if (strobe.load) begin
      found    <= 1'b0;
      matchIdx <= '0;
    end else if (strobe.capture) begin
      found    <= 1'b1;
      matchIdx <= idx;
    end
  end

endmodule

// File: rtl/amap_matcher.sv
module amap_matcher
  import amap_pkg::*;
#(
  parameter int COL_W = 4,
  parameter int ROW_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [COL_W-1:0]     colBits,
  input  logic [ROW_W-1:0]     rowBits,
  input  logic                 busIs16,
  input  logic [1:0]           scheme,
  output logic                 done,
  output logic                 found,
  output logic [MAP_IDX_W-1:0] matchIdx
);

  ctrl_strobe_t         strobe;
  logic                 hit;
  logic [MAP_IDX_W-1:0] idx;

  amap_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .hit    (hit),
    .strobe (strobe),
    .idx    (idx),
    .done   (done)
  );

  amap_dpath #(.COL_W(COL_W), .ROW_W(ROW_W)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .colBits  (colBits),
    .rowBits  (rowBits),
    .busIs16  (busIs16),
    .scheme   (scheme),
    .idx      (idx),
    .hit      (hit),
    .found    (found),
    .matchIdx (matchIdx)
  );

endmodule

// File: rtl/amap_matcher_chk.sv
module amap_matcher_chk
  import amap_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 done,
  input logic                 found,
  input logic [MAP_IDX_W-1:0] matchIdx
);

  logic       busy;
  logic [5:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && (!busy || done)) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy && !done) begin
      cnt <= cnt + 1'b1;
    end else if (busy && done) begin
      busy <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(found) && $stable(matchIdx)); // R8

  AST_RESTART_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done && start |=> !done); // R8

  AST_NOTFOUND_ZERO_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    done && !found |-> matchIdx == '0); // R6

  AST_FOUND_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> done); // R6

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (found ? (cnt == 6'({2'b00, matchIdx}) + 6'd1) : (cnt == 6'd16))); // R7

  AST_SEARCH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt <= 6'd16); // R7

endmodule

bind amap_matcher amap_matcher_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .done     (done),
  .found    (found),
  .matchIdx (matchIdx)
);

// File: tb/amap_matcher_bench.sv
module amap_matcher_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] colBits = '0;
  logic [4:0] rowBits = '0;
  logic       busIs16 = 1'b0;
  logic [1:0] scheme = '0;
  logic       done, found;
  logic [3:0] matchIdx;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  amap_matcher u_amap_matcher (
    .clk(clk), .rst_n(rst_n), .start(start), .colBits(colBits),
    .rowBits(rowBits), .busIs16(busIs16), .scheme(scheme),
    .done(done), .found(found), .matchIdx(matchIdx)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Table from R2, scheme codes 0/1/2
  function automatic int tRows(input int i);
    int r[16] = '{13,14,15,16,14,15,16,13,14,15,16,15,14,13,16,16};
    return r[i];
  endfunction
  function automatic int tCols(input int i);
    int c[16] = '{10,10,10,10,11,11,11,9,9,9,9,10,11,10,10,9};
    return c[i];
  endfunction
  function automatic int tSch(input int i);
    return (i <= 10) ? 0 : ((i <= 13) ? 1 : 2);
  endfunction

  // Expected result from R1..R6; returns index or -1 when none matches
  function automatic int model(input int c, input int r, input bit b16, input int s);
    int ec = b16 ? c - 1 : c;
    for (int i = 0; i < 16; i++) begin
      bit ok = 1'b0;
      if (tSch(i) == s) begin
        if (s == 0) ok = (tCols(i) == ec) && (tRows(i) == r);
        else if (s == 1) ok = (tCols(i) == ec) && (tRows(i) <= r);
        else ok = (tCols(i) == ec) || ((tCols(i) <= ec) && (tRows(i) == r));
      end
      if (ok) return i;
    end
    return -1;
  endfunction

  task automatic pulseStart(input int c, input int r, input bit b16, input int s);
    colBits = 4'(c); rowBits = 5'(r); busIs16 = b16; scheme = 2'(s);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output int lat);
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic runSearch(input string req, input int c, input int r, input bit b16, input int s);
    int exp = model(c, r, b16, s);
    int lat;
    pulseStart(c, r, b16, s);
    chk({req, " R8 done low after start"}, done, 0);
    waitDone(lat);
    chk({req, " R6 found"}, found, exp >= 0);
    chk({req, " R6 index"}, matchIdx, exp >= 0 ? exp : 0);
    chk({req, " R7 latency"}, lat, exp >= 0 ? exp + 1 : 16);
  endtask

  task automatic testReset();
    chk("R10 done", done, 0);
    chk("R10 found", found, 0);
    chk("R10 index", matchIdx, 0);
  endtask

  task automatic testExact();
    runSearch("R3 13x10", 10, 13, 0, 0);
    runSearch("R3 16x9", 9, 16, 0, 0);
    runSearch("R3 no row 12", 10, 12, 0, 0);
    chk("R3 expect index 10 on 16x9 path", model(9, 16, 0, 0), 10);
  endtask

  task automatic testBus16();
    runSearch("R1 16bit 11c 16r", 11, 16, 1, 0);
    chk("R1 result index", matchIdx, 3);
    runSearch("R1 32bit 11c 16r", 11, 16, 0, 0);
    chk("R1 result index 32bit", matchIdx, 6);
  endtask

  task automatic testAtLeast();
    runSearch("R4 10c 16r", 10, 16, 0, 1);
    chk("R4 picks 11", matchIdx, 11);
    runSearch("R4 10c 13r first-fit", 10, 13, 0, 1);
    chk("R6 lowest fitting is 13", matchIdx, 13);
    runSearch("R4 11c 13r none", 11, 13, 0, 1);
  endtask

  task automatic testColOrRow();
    runSearch("R5 10c 12r col-eq", 10, 12, 0, 2);
    chk("R5 index 14", matchIdx, 14);
    runSearch("R5 11c 16r row-eq", 11, 16, 0, 2);
    chk("R5 index 14 via rows", matchIdx, 14);
    runSearch("R5 9c 13r", 9, 13, 0, 2);
    chk("R5 index 15", matchIdx, 15);
    runSearch("R5 11c 15r none", 11, 15, 0, 2);
  endtask

  task automatic testUnusedScheme();
    runSearch("R2 code 3", 10, 13, 0, 3);
    chk("R2 code 3 not found", found, 0);
  endtask

  task automatic testIgnoreDuringScan();
    int lat;
    pulseStart(9, 13, 0, 2);
    repeat (2) @(negedge clk);
    pulseStart(10, 13, 0, 0);
    colBits = 4'd11; rowBits = 5'd16; scheme = 2'd1;
    waitDone(lat);
    chk("R9 latency unchanged", lat + 3, 16);
    chk("R9 found", found, 1);
    chk("R9 index from first search", matchIdx, 15);
  endtask

  task automatic testHold();
    logic [3:0] keepIdx = matchIdx;
    logic       keepFound = found;
    repeat (5) @(negedge clk);
    chk("R8 done held", done, 1);
    chk("R8 found held", found, keepFound);
    chk("R8 index held", matchIdx, keepIdx);
  endtask

  task automatic testRestartFromDone();
    chk("R8 precondition done", done, 1);
    runSearch("R8 restart 10c 16r", 10, 16, 0, 0);
    chk("R8 new index", matchIdx, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testExact();
    testBus16();
    testAtLeast();
    testColOrRow();
    testUnusedScheme();
    testIgnoreDuringScan();
    testHold();
    testRestartFromDone();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule